// File: doc/BRIEF.md
# Multi-Master Hardware Semaphore Bank

This block holds a bank of hardware semaphores that several processors on one chip use to serialize access to shared resources. Each master reaches the bank through its own 32-bit register port. Every access carries the master's 4-bit identity on a sideband. To take a semaphore, a master writes its identity into that semaphore's register. It then reads the register back and compares the low nibble with its own identity. A match means the master holds the semaphore. Any other value means the semaphore is held by another master or is free.

Only the recorded owner can free a semaphore, and it does so by writing zero. A claim written to a semaphore that is already held is dropped, so the current owner stays in place. When several ports write the same register in one cycle, the lowest-indexed port whose write is valid against the current state wins. The bank also has a control word, whose bit 0 selects the protocol. It has an interrupt-clear location as well. No interrupts are generated, so that location has nothing to clear and always reads as zero.

Top module: `hsem_bank`

## Requirements
- R1: After reset, every semaphore reads 0 and the control register reads 0.
- R2: Semaphore i is the word at byte address 8 + 4*i, so semaphore 0 is at 0x08 and semaphore 31 is at 0x84. A free semaphore reads 0.
- R3: A write whose bits [3:0] are nonzero, sent to a free semaphore, records bits [3:0] as the owner, and the bits above them are ignored. The register then reads as the owner ID in bits [3:0], with all higher bits 0.
- R4: A write with nonzero bits [3:0] to a semaphore that is already held is ignored, and the owner is unchanged.
- R5: A write with bits [3:0] equal to 0 frees a held semaphore only when the writing port's master-ID sideband equals the stored owner. Such a write from any other master is ignored.
- R6: When several ports write one semaphore in the same cycle, only the write from the lowest-indexed port that is valid against the current state takes effect. This applies to both claims and releases.
- R7: The control register at 0x00 stores write-data bit 0 and reads it back in bit 0, with bits [31:1] reading 0. If several ports write it in one cycle, the lowest port index wins.
- R8: A write to the interrupt-clear address 0x90 (for example 0xFFFF) changes no state, and reads of 0x90 return 0. Reads of addresses that are unmapped or not word-aligned return 0, and writes to them change nothing.
- R9: Read data is combinational. While the read enable is high it shows the state from before any write in the same cycle. A write becomes visible from the next cycle on. While the read enable is low, the read data is 0.
- R10: Semaphores are independent: an access to one never changes another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | NPORTS*8 | Byte address, one 8-bit field per port |
| bus_we | input | NPORTS | Write enable, one bit per port |
| bus_wdata | input | NPORTS*32 | Write data, one 32-bit field per port |
| bus_re | input | NPORTS | Read enable, one bit per port |
| bus_mid | input | NPORTS*4 | Master ID of the current access, one 4-bit field per port |
| bus_rdata | output | NPORTS*32 | Read data, one 32-bit field per port |

## Verification
The hardest situation to reach is two ports writing the same semaphore in the same cycle. It is hardest of all when the lower port's write is invalid, such as a release from a non-owner, and the higher port's write is valid. The stimulus sets up both ports in one cycle for directed cases of this kind. A randomized phase then keeps many accesses aimed at a small set of semaphores, using few master IDs, so that collisions, stolen claims and foreign releases happen often. A behavioural model checks every read against the state it predicts.

// File: rtl/hsem_bank.sv
module hsem_bank #(
  parameter int NPORTS    = 2,
  parameter int NSEM      = 32,
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int IDW       = 4,
  parameter int SEM_BASE  = 8,
  parameter int CTRL_ADDR = 0,
  parameter int ICLR_ADDR = 144
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORTS*AW-1:0]  bus_addr,
  input  logic [NPORTS-1:0]     bus_we,
  input  logic [NPORTS*DW-1:0]  bus_wdata,
  input  logic [NPORTS-1:0]     bus_re,
  input  logic [NPORTS*IDW-1:0] bus_mid,
  output logic [NPORTS*DW-1:0]  bus_rdata
);
  localparam int SEM_END = SEM_BASE + 4 * NSEM;
  localparam int SW = (NSEM > 1) ? $clog2(NSEM) : 1;

  logic [NSEM-1:0][IDW-1:0] own, own_nx;
  logic ctrl, ctrl_nx;
  logic [NPORTS-1:0] is_sem, is_ctrl;
  logic [NPORTS-1:0][SW-1:0] sidx;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [AW-1:0] a;
    assign a = bus_addr[p*AW +: AW];
    assign is_sem[p]  = (int'(a) >= SEM_BASE) && (int'(a) < SEM_END) && (a[1:0] == 2'b00);
    assign is_ctrl[p] = (int'(a) == CTRL_ADDR);
    assign sidx[p]    = SW'((int'(a) - SEM_BASE) >> 2);
    always_comb begin
      bus_rdata[p*DW +: DW] = '0;
      if (bus_re[p]) begin
        if (is_sem[p])       bus_rdata[p*DW +: DW] = DW'(own[sidx[p]]);
        else if (is_ctrl[p]) bus_rdata[p*DW +: DW] = DW'(ctrl);
      end
    end
  end

  always_comb begin
    logic done;
    logic [IDW-1:0] wid, mid;
    own_nx = own;
    for (int s = 0; s < NSEM; s++) begin
      done = 1'b0;
      for (int p = 0; p < NPORTS; p++) begin
        wid = bus_wdata[p*DW +: IDW];
        mid = bus_mid[p*IDW +: IDW];
        if (!done && bus_we[p] && is_sem[p] && sidx[p] == SW'(s)) begin
          if (own[s] == '0 && wid != '0) begin
            own_nx[s] = wid;
            done = 1'b1;
          end else if (own[s] != '0 && wid == '0 && mid == own[s]) begin
            own_nx[s] = '0;
            done = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    ctrl_nx = ctrl;
    for (int p = NPORTS - 1; p >= 0; p--)
      if (bus_we[p] && is_ctrl[p]) ctrl_nx = bus_wdata[p*DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own  <= '0;
      ctrl <= 1'b0;
    end else begin
      own  <= own_nx;
      ctrl <= ctrl_nx;
    end
  end
endmodule

module hsem_bank_chk #(
  parameter int NPORTS    = 2,
  parameter int NSEM      = 32,
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int IDW       = 4,
  parameter int SEM_BASE  = 8,
  parameter int CTRL_ADDR = 0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPORTS*AW-1:0]     bus_addr,
  input logic [NPORTS-1:0]        bus_we,
  input logic [NPORTS*DW-1:0]     bus_wdata,
  input logic [NPORTS-1:0]        bus_re,
  input logic [NPORTS*IDW-1:0]    bus_mid,
  input logic [NPORTS*DW-1:0]     bus_rdata,
  input logic [NSEM-1:0][IDW-1:0] own
);
  logic [NSEM-1:0] rel_req, wr_any;

  always_comb begin
    rel_req = '0;
    wr_any  = '0;
    for (int s = 0; s < NSEM; s++)
      for (int p = 0; p < NPORTS; p++)
        if (bus_we[p] && int'(bus_addr[p*AW +: AW]) == SEM_BASE + 4 * s) begin
          wr_any[s] = 1'b1;
          if (bus_wdata[p*DW +: IDW] == '0 && bus_mid[p*IDW +: IDW] == own[s])
            rel_req[s] = 1'b1;
        end
  end

  for (genvar s = 0; s < NSEM; s++) begin : g_sem
    AST_NO_STEAL: assert property (@(posedge clk) disable iff (!rst_n)
      (own[s] != '0) |=> (own[s] == $past(own[s]) || own[s] == '0)); // R4
    AST_OWNER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (own[s] != '0 && !rel_req[s]) |=> (own[s] == $past(own[s]))); // R5
    AST_CLAIM_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (own[s] == '0 && !wr_any[s]) |=> (own[s] == '0)); // R3
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_prt
    logic [AW-1:0] a;
    logic mapped;
    assign a = bus_addr[p*AW +: AW];
    assign mapped = (int'(a) == CTRL_ADDR) ||
                    ((int'(a) >= SEM_BASE) && (int'(a) < SEM_BASE + 4 * NSEM) && (a[1:0] == 2'b00));
    AST_SEM_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(a) >= SEM_BASE) |-> (bus_rdata[p*DW+IDW +: DW-IDW] == '0)); // R3
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!mapped || !bus_re[p]) |-> (bus_rdata[p*DW +: DW] == '0)); // R8
    AST_CTRL_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(a) == CTRL_ADDR) |-> (bus_rdata[p*DW+1 +: DW-1] == '0)); // R7
  end
endmodule

bind hsem_bank hsem_bank_chk #(
  .NPORTS(NPORTS), .NSEM(NSEM), .AW(AW), .DW(DW), .IDW(IDW),
  .SEM_BASE(SEM_BASE), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_mid(bus_mid),
  .bus_rdata(bus_rdata), .own(own)
);

// File: tb/hsem_bank_test.sv
`timescale 1ns/1ps
module hsem_bank_test;
  localparam int NP = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP*8-1:0]  bus_addr = '0;
  logic [NP-1:0]    bus_we = '0;
  logic [NP*32-1:0] bus_wdata = '0;
  logic [NP-1:0]    bus_re = '0;
  logic [NP*4-1:0]  bus_mid = '0;
  logic [NP*32-1:0] bus_rdata;

  int tests = 0;
  int fails = 0;
  int owner[32];
  int ctrl_m;

  always #5 clk = ~clk;

  hsem_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_mid(bus_mid), .bus_rdata(bus_rdata)
  );

  always @(posedge clk) begin
    int nxt[32];
    if (!rst_n) begin
      foreach (owner[i]) owner[i] = 0;
      ctrl_m = 0;
    end else begin
      nxt = owner;
      for (int s = 0; s < 32; s++) begin
        bit taken = 0;
        for (int p = 0; p < NP; p++) begin
          int w = bus_wdata[p*32 +: 4];
          int m = bus_mid[p*4 +: 4];
          if (!taken && bus_we[p] && bus_addr[p*8 +: 8] == 8 + 4 * s) begin
            if (owner[s] == 0 && w != 0) begin nxt[s] = w; taken = 1; end
            else if (owner[s] != 0 && w == 0 && m == owner[s]) begin nxt[s] = 0; taken = 1; end
          end
        end
      end
      for (int p = NP - 1; p >= 0; p--)
        if (bus_we[p] && bus_addr[p*8 +: 8] == 0) ctrl_m = bus_wdata[p*32];
      owner = nxt;
    end
  end

  function automatic int model_read(int a);
    if (a >= 8 && a < 8 + 128 && a % 4 == 0) return owner[(a - 8) / 4];
    if (a == 0) return ctrl_m;
    return 0;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic idle();
    bus_we = '0; bus_re = '0; bus_addr = '0; bus_wdata = '0; bus_mid = '0;
  endtask

  task automatic set_port(int p, bit we, bit re, int a, logic [31:0] d, int m);
    bus_we[p] = we; bus_re[p] = re; bus_addr[p*8 +: 8] = 8'(a);
    bus_wdata[p*32 +: 32] = d; bus_mid[p*4 +: 4] = 4'(m);
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic wr(int p, int a, logic [31:0] d, int m);
    set_port(p, 1, 0, a, d, m); tick();
  endtask

  task automatic rd(string req, int p, int a, logic [31:0] exp);
    set_port(p, 0, 1, a, 0, 0); #1;
    check(req, bus_rdata[p*32 +: 32], exp);
    tick();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 32; s++) rd("R1", s % NP, 8 + 4 * s, 0);
    rd("R1", 0, 0, 0);

    wr(0, 8'h08, 32'h3, 3);
    rd("R3", 1, 8'h08, 3);
    wr(1, 8'h84, 32'hABCD_0005, 5);
    rd("R2", 0, 8'h84, 5);
    rd("R10", 0, 8'h80, 0);

    wr(1, 8'h08, 32'h7, 7);
    rd("R4", 0, 8'h08, 3);
    wr(1, 8'h08, 32'h0, 7);
    rd("R5", 0, 8'h08, 3);
    wr(0, 8'h08, 32'h0, 3);
    rd("R5", 1, 8'h08, 0);

    set_port(0, 1, 0, 8'h18, 32'h2, 2);
    set_port(1, 1, 0, 8'h18, 32'h9, 9);
    tick();
    rd("R6", 1, 8'h18, 2);
    set_port(0, 1, 0, 8'h18, 32'h0, 6);
    set_port(1, 1, 0, 8'h18, 32'h0, 2);
    tick();
    rd("R6", 0, 8'h18, 0);

    set_port(0, 1, 1, 8'h0C, 32'h4, 4); #1;
    check("R9", bus_rdata[31:0], 0);
    tick();
    rd("R9", 0, 8'h0C, 4);
    set_port(1, 0, 0, 8'h0C, 0, 0); #1;
    check("R9", bus_rdata[63:32], 0);
    tick();

    wr(1, 0, 32'hFFFF_FFFF, 1);
    rd("R7", 0, 0, 1);
    set_port(0, 1, 0, 0, 32'h0, 1);
    set_port(1, 1, 0, 0, 32'h1, 2);
    tick();
    rd("R7", 1, 0, 0);

    wr(0, 8'h90, 32'hFFFF, 1);
    rd("R8", 1, 8'h90, 0);
    wr(0, 8'h0E, 32'h5, 5);
    rd("R8", 0, 8'h0E, 0);
    rd("R8", 1, 8'hA0, 0);
    rd("R8", 1, 8'h84, 5);
    rd("R8", 0, 8'h0C, 4);

    for (int c = 0; c < 4000; c++) begin
      for (int p = 0; p < NP; p++) begin
        int k = $urandom_range(0, 9);
        int a = (k < 7) ? 8 + 4 * $urandom_range(0, 3) : (k == 7 ? 0 : (k == 8 ? 8'h90 : 8'h86));
        int m = $urandom_range(1, 3);
        logic [31:0] d = ($urandom_range(0, 2) == 0) ? {$urandom_range(0, 255), 4'h0} & 32'hFF0 : {28'($urandom), 4'(m)};
        set_port(p, $urandom_range(0, 1) == 1, 1, a, d, m);
      end
      #1;
      for (int p = 0; p < NP; p++)
        check("R6/R10", bus_rdata[p*32 +: 32], 32'(model_read(int'(bus_addr[p*8 +: 8]))));
      tick();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule